// File: doc/BRIEF.md
# Sequenced PI Current Regulator

This block computes a current command from a reference current sample and a measured load current sample. It uses one shared arithmetic unit and a sixteen-slot register file. A fixed schedule of 29 working steps drives both. Each arithmetic step takes two cycles: a compute cycle that reads up to two slots and selects an operation, then a store cycle that writes the result into a fixed slot.

The schedule captures the two samples. It scales each sample by the current limit and shifts it down to form the error. It then applies an incremental proportional-integral law, dy = K·(e − e_prev). The new output is y = y_prev + dy. Finally the result is shifted down and clamped to the current limit. The previous error and the previous output stay in the register file from one run to the next. This is how the regulator keeps its history.

The caller raises `go` and holds it while updates are wanted. A one-cycle `icmd_vld` strobe marks each new command. With `go` held, a new run starts directly after each strobe.

Top module: `pi_seq_reg`

## Requirements
- R1: When `go` is high and the block is idle, a run starts on the next clock edge. `icmd_vld` goes high in the 29th cycle of the run, counting the first working cycle as cycle 1. With `go` held high, the next run starts immediately, so strobes come exactly 29 cycles apart.
- R2: While `rst` is 1, or `go` is 0, the block returns to idle on the next edge. A run that is cut short by `go` falling produces no strobe and leaves `icmd` unchanged.
- R3: `iref_smp` is sampled only at the end of the first working cycle, and `iload_smp` only at the end of the second. Later changes to either input during the run have no effect on that run's result.
- R4: All arithmetic is 16-bit signed two's complement that wraps. The error is e = (lo16(ref·IMAX) >>> 5) + (lo16(load·(−IMAX)) >>> 5). Here lo16 keeps the low 16 bits of the product, and >>> is an arithmetic shift.
- R5: The increment is dy = lo16((e·K) >>> 8) + lo16((e_prev·(−K)) >>> 8). The output is y = y_prev + dy. After each complete run, the block stores e as e_prev and y as y_prev for the next run.
- R6: The command is y >>> 5, clamped to the range [−IMAX, +IMAX]. It is loaded into `icmd` on the edge that raises `icmd_vld`. `icmd_vld` stays high for exactly one cycle.
- R7: `icmd` changes only on the edge that raises `icmd_vld`. It holds its value at all other times.
- R8: Reset clears `icmd`, `icmd_vld`, e_prev and y_prev to zero, and reloads the constants +IMAX, −IMAX, +K and −K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Run request; low forces idle |
| iref_smp | input | 16 | Signed reference current sample |
| iload_smp | input | 16 | Signed load current sample |
| icmd | output | 16 | Signed, limited current command |
| icmd_vld | output | 1 | One-cycle strobe marking a new command |

## Verification
Two events overlap in one cycle: the end-of-run strobe and the start of the next run. When `go` stays high through the strobe cycle, the next edge both finishes the output and restarts at step 0, with fresh inputs already applied.

The bench holds `go` across runs in randomly chosen places and changes the samples in the strobe cycle. It judges the overlap in two ways: the next strobe must come exactly 29 cycles later, and its value must match a bit-accurate model. That model carries e_prev and y_prev forward. In other places the bench drops `go` in the strobe cycle and confirms that the block goes idle with no second strobe.

// File: rtl/pi_seq_reg.sv
module pi_seq_reg #(
  parameter int W    = 16,
  parameter int AW   = 4,
  parameter int IMAX = 500,
  parameter int KPI  = 6000,
  parameter int FRAC = 8,
  parameter int SHR  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic signed [W-1:0] iref_smp,
  input  logic signed [W-1:0] iload_smp,
  output logic signed [W-1:0] icmd,
  output logic                icmd_vld
);

  localparam int DEPTH = 1 << AW;
  localparam logic [4:0] LAST   = 5'd28;
  localparam logic [4:0] OUT_LD = 5'd27;

  localparam logic signed [W-1:0] C_PMAX = W'(IMAX);
  localparam logic signed [W-1:0] C_NMAX = W'(-IMAX);
  localparam logic signed [W-1:0] C_KP   = W'(KPI);
  localparam logic signed [W-1:0] C_KN   = W'(-KPI);

  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_GMUL = 3'b001;
  localparam logic [2:0] OP_CMUL = 3'b010;
  localparam logic [2:0] OP_SHR  = 3'b011;
  localparam logic [2:0] OP_PASS = 3'b100;
  localparam logic [2:0] OP_LIM  = 3'b101;

  localparam logic [1:0] SEL_ALU  = 2'b00;
  localparam logic [1:0] SEL_REF  = 2'b01;
  localparam logic [1:0] SEL_LOAD = 2'b10;

  localparam logic [AW-1:0] A_REF  = AW'(0);
  localparam logic [AW-1:0] A_LOAD = AW'(1);
  localparam logic [AW-1:0] A_PMAX = AW'(2);
  localparam logic [AW-1:0] A_NMAX = AW'(3);
  localparam logic [AW-1:0] A_EPRV = AW'(4);
  localparam logic [AW-1:0] A_KP   = AW'(5);
  localparam logic [AW-1:0] A_KN   = AW'(6);
  localparam logic [AW-1:0] A_SA   = AW'(8);
  localparam logic [AW-1:0] A_SB   = AW'(9);
  localparam logic [AW-1:0] A_YPRV = AW'(10);
  localparam logic [AW-1:0] A_ERR  = AW'(11);
  localparam logic [AW-1:0] A_PA   = AW'(12);
  localparam logic [AW-1:0] A_PB   = AW'(13);
  localparam logic [AW-1:0] A_SUM  = AW'(14);
  localparam logic [AW-1:0] A_Y    = AW'(15);

  logic                busy;
  logic [4:0]          step;
  logic [AW-1:0]       ra, rb, wa;
  logic [2:0]          op;
  logic [1:0]          sel;
  logic                we;
  logic signed [W-1:0] ram [DEPTH];
  logic signed [W-1:0] opa, opb, nb, alu_y, alu_q, wdata;
  logic signed [2*W-1:0] xa, xb, prod;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      busy <= 1'b1;
      step <= '0;
    end else if (step == LAST) begin
      step <= '0;
    end else begin
      step <= step + 5'd1;
    end
  end

  always_comb begin
    ra  = A_REF;
    rb  = A_REF;
    op  = OP_PASS;
    we  = 1'b0;
    wa  = A_REF;
    sel = SEL_ALU;
    unique case (step)
      5'd0:  begin we = 1'b1; wa = A_REF;  sel = SEL_REF;  end
      5'd1:  begin we = 1'b1; wa = A_LOAD; sel = SEL_LOAD; end
      5'd2:  begin ra = A_REF;  rb = A_PMAX; op = OP_GMUL; end
      5'd3:  begin we = 1'b1; wa = A_SA; end
      5'd4:  begin ra = A_LOAD; rb = A_NMAX; op = OP_GMUL; end
      5'd5:  begin we = 1'b1; wa = A_SB; end
      5'd6:  begin ra = A_SA; op = OP_SHR; end
      5'd7:  begin we = 1'b1; wa = A_SA; end
      5'd8:  begin ra = A_SB; op = OP_SHR; end
      5'd9:  begin we = 1'b1; wa = A_SB; end
      5'd10: begin ra = A_SA; rb = A_SB; op = OP_ADD; end
      5'd11: begin we = 1'b1; wa = A_ERR; end
      5'd12: begin ra = A_ERR; rb = A_KP; op = OP_CMUL; end
      5'd13: begin we = 1'b1; wa = A_PA; end
      5'd14: begin ra = A_EPRV; rb = A_KN; op = OP_CMUL; end
      5'd15: begin we = 1'b1; wa = A_PB; end
      5'd16: begin ra = A_ERR; op = OP_PASS; end
      5'd17: begin we = 1'b1; wa = A_EPRV; end
      5'd18: begin ra = A_PA; rb = A_PB; op = OP_ADD; end
      5'd19: begin we = 1'b1; wa = A_SUM; end
      5'd20: begin ra = A_SUM; rb = A_YPRV; op = OP_ADD; end
      5'd21: begin we = 1'b1; wa = A_Y; end
      5'd22: begin ra = A_Y; op = OP_PASS; end
      5'd23: begin we = 1'b1; wa = A_YPRV; end
      5'd24: begin ra = A_Y; op = OP_SHR; end
      5'd25: begin we = 1'b1; wa = A_SUM; end
      5'd26: begin ra = A_SUM; rb = A_PMAX; op = OP_LIM; end
      default: ;
    endcase
  end

  assign opa  = ram[ra];
  assign opb  = ram[rb];
  assign nb   = -opb;
  assign xa   = {{W{opa[W-1]}}, opa};
  assign xb   = {{W{opb[W-1]}}, opb};
  assign prod = xa * xb;

  always_comb begin
    unique case (op)
      OP_ADD:  alu_y = opa + opb;
      OP_GMUL: alu_y = W'(prod);
      OP_CMUL: alu_y = W'(prod >>> FRAC);
      OP_SHR:  alu_y = opa >>> SHR;
      OP_LIM:  alu_y = (opa > opb) ? opb : ((opa < nb) ? nb : opa);
      default: alu_y = opa;
    endcase
  end

  always_comb begin
    unique case (sel)
      SEL_REF:  wdata = iref_smp;
      SEL_LOAD: wdata = iload_smp;
      default:  wdata = alu_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
      ram[A_PMAX] <= C_PMAX;
      ram[A_NMAX] <= C_NMAX;
      ram[A_KP]   <= C_KP;
      ram[A_KN]   <= C_KN;
    end else if (busy && we) begin
      ram[wa] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_q <= '0;
      icmd  <= '0;
    end else begin
      alu_q <= alu_y;
      if (busy && step == OUT_LD) icmd <= alu_q;
    end
  end

  assign icmd_vld = busy && (step == LAST);

endmodule

// File: rtl/pi_seq_chk.sv
module pi_seq_chk #(
  parameter int W    = 16,
  parameter int IMAX = 500
) (
  input logic                clk,
  input logic                rst,
  input logic                go,
  input logic                busy,
  input logic [4:0]          step,
  input logic signed [W-1:0] icmd,
  input logic                icmd_vld
);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!icmd_vld && icmd == '0));

  a_r2_go_low_idles: assert property (@(posedge clk) disable iff (rst)
    !go |=> !busy);

  a_r1_step_order: assert property (@(posedge clk) disable iff (rst)
    (busy && go && step != 5'd28) |=> (busy && step == $past(step) + 5'd1));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    icmd_vld |=> !icmd_vld);

  a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
    icmd_vld |-> (icmd <= IMAX && icmd >= -IMAX));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(icmd) |-> icmd_vld);

endmodule

bind pi_seq_reg pi_seq_chk #(.W(W), .IMAX(IMAX)) u_chk (
  .clk(clk), .rst(rst), .go(go), .busy(busy), .step(step),
  .icmd(icmd), .icmd_vld(icmd_vld)
);

// File: tb/test_pi_seq_reg.sv
`timescale 1ns/1ps
module test_pi_seq_reg;
  localparam int W = 16, IMAX = 500, KPI = 6000, FRAC = 8, SHR = 5;
  localparam logic signed [2*W-1:0] BMAX = IMAX;
  localparam logic signed [2*W-1:0] BK   = KPI;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic signed [W-1:0] iref = '0, iload = '0;
  wire  signed [W-1:0] icmd;
  wire                 icmd_vld;

  always #2.5 clk = ~clk;

  pi_seq_reg #(.W(W), .AW(4), .IMAX(IMAX), .KPI(KPI), .FRAC(FRAC), .SHR(SHR)) i_pi_seq_reg (
    .clk(clk), .rst(rst), .go(go), .iref_smp(iref), .iload_smp(iload),
    .icmd(icmd), .icmd_vld(icmd_vld)
  );

  int n_chk = 0, n_fail = 0;
  logic signed [W-1:0] m_eprv = '0, m_yprv = '0, last_cmd = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] model(input logic signed [W-1:0] r, input logic signed [W-1:0] l);
    logic signed [2*W-1:0] p, xr, xl, xe, xp;
    logic signed [W-1:0] a, b, e, d1, d2, y, s;
    xr = r; xl = l; xe = '0; xp = m_eprv;
    p = xr * BMAX;    a = p[W-1:0]; a = a >>> SHR;
    p = xl * (-BMAX); b = p[W-1:0]; b = b >>> SHR;
    e = a + b;
    xe = e;
    p = (xe * BK) >>> FRAC;    d1 = p[W-1:0];
    p = (xp * (-BK)) >>> FRAC; d2 = p[W-1:0];
    y = m_yprv + (d1 + d2);
    m_eprv = e;
    m_yprv = y;
    s = y >>> SHR;
    if (s > IMAX) s = W'(IMAX);
    else if (s < -IMAX) s = W'(-IMAX);
    return s;
  endfunction

  // Called at a negedge; returns at the negedge of the strobe cycle.
  task automatic run_one(input logic signed [W-1:0] r, input logic signed [W-1:0] l,
                         input bit keep, input bit scramble, output logic signed [W-1:0] got_cmd);
    logic signed [W-1:0] exp;
    int cnt;
    bit got, held, early;
    iref = r; iload = l; go = 1'b1;
    exp = model(r, l);
    cnt = 0; got = 0; held = 1; early = 0;
    while (!got && cnt < 60) begin
      @(negedge clk);
      cnt++;
      if (scramble && cnt == 3) begin
        iref = W'($urandom);
        iload = W'($urandom);
      end
      if (icmd_vld) got = 1;
      else if (icmd !== last_cmd) held = 0;
      if (icmd_vld && cnt < 29) early = 1;
    end
    check(got && cnt == 29 && !early, "R1 strobe cycle", cnt, 29);
    check(icmd === exp, "R4 R5 R6 command value (R3 when scrambled)", icmd, exp);
    check(held, "R7 hold between strobes", icmd, last_cmd);
    last_cmd = icmd;
    got_cmd = icmd;
    if (!keep) begin
      go = 1'b0;
      @(negedge clk);
      check(!icmd_vld, "R6 one-cycle strobe", icmd_vld, 0);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(icmd === '0 && !icmd_vld, "R8 reset state", icmd, 0);
    rst = 1'b0;
    m_eprv = '0; m_yprv = '0; last_cmd = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic signed [W-1:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    do_reset();

    run_one(16'sd0, 16'sd0, 1'b0, 1'b0, c);
    check(c === 16'sd0, "R4 zero inputs", c, 0);
    run_one(16'sd60, 16'sd0, 1'b0, 1'b0, c);
    check(c === 16'sd500, "R6 clamp high", c, 500);

    do_reset();
    run_one(16'sd0, 16'sd60, 1'b0, 1'b1, c);
    check(c === -16'sd500, "R6 clamp low", c, -500);
    run_one(16'sd20, 16'sd5, 1'b1, 1'b0, c);
    run_one(16'sd20, 16'sd5, 1'b0, 1'b0, c);

    // R2: abort a run early, before any history slot is written
    iref = 16'sd77; iload = -16'sd33; go = 1'b1;
    repeat (6) @(negedge clk);
    go = 1'b0;
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (icmd_vld || icmd !== last_cmd) quiet = 0;
      end
      check(quiet, "R2 aborted run leaves no strobe", icmd, last_cmd);
    end

    for (int i = 0; i < 30; i++) begin
      logic signed [W-1:0] r, l;
      if (i % 5 == 4) begin
        r = W'($urandom); l = W'($urandom);
      end else begin
        r = W'($urandom_range(0, 255)) - 16'sd128;
        l = W'($urandom_range(0, 255)) - 16'sd128;
      end
      run_one(r, l, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), c);
    end
    go = 1'b0;
    @(negedge clk);

    do_reset();
    run_one(16'sd10, -16'sd10, 1'b0, 1'b0, c);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule